// File: doc/BRIEF.md
# Switch Host Register Interface

This block is the parallel host port of a time-slot switch. A host sees a 64-byte space through a 6-bit address. The lower half reaches one control byte. The upper half is a 32-byte window onto one of three banked memories: the data memory, the low connection memory or the high connection memory. Fields of the control byte choose which memory and which of four streams the window covers. Within that stream the five low address bits pick the channel.

The control byte also holds a split-access flag and a global processor-mode flag. With the split flag set, window reads come from the data memory and window writes go to the low connection memory, whatever the memory field says. The processor-mode flag leaves the block as a plain output for the switch core.

The host starts an access by raising `host_rd` or `host_wr` with the address and data held steady. It waits for the one-cycle `host_done` pulse, then drops the strobe. A new access starts only after both strobes have been seen low. Memory accesses go out on a request/grant port that the switch core arbitrates. `mem_req` is the valid and `mem_gnt` the ready. The core may hold off the grant for any number of cycles. The request and its fields stay stable until the cycle in which the grant is high, and the read data is taken in that same cycle.

Top module: `swhost_port`

## Requirements
- R1: After reset the control byte is 0, `proc_mode` is 0, and `host_done` and `mem_req` are 0.
- R2: An access with address bit 5 low reaches the control byte, and address bits 4 to 0 have no effect on it.
- R3: Control bits 5 and 2 always read back as 0, and the other six bits read back as written.
- R4: A control access raises `host_done` in the cycle after the strobe is first seen.
- R5: A window access (address bit 5 high) presents channel = address bits 4..0 and stream = control bits 1..0 on the memory port.
- R6: Control bits 4..3 select the memory: 01 is the data memory, 10 the low connection memory, 11 the high connection memory. `mem_sel` carries the same code.
- R7: When control bit 7 is 1, window reads use the data memory (`mem_sel` 01) and window writes use the low connection memory (`mem_sel` 10), whatever bits 4..3 hold.
- R8: A window write aimed at the data memory, or made with the reserved select 00, raises no memory request, changes no memory and completes in one cycle. A window read with select 00 returns 0 in one cycle.
- R9: A read of a high connection byte returns the stored bits 2 and 0, with every other bit 0.
- R10: A memory access keeps `mem_req` and its fields stable until it is granted, raises `host_done` only in the cycle after the grant, and so completes 2 + (wait cycles) cycles after the strobe.
- R11: `proc_mode` follows control bit 6.
- R12: `host_done` is a single-cycle pulse. A strobe held high after done starts no second access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 6 | Host address; bit 5 picks window or control byte |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Read strobe, held until done |
| host_wr | input | 1 | Write strobe, held until done; wins over read |
| host_rdata | output | 8 | Read result, valid with done |
| host_done | output | 1 | Access-complete pulse |
| proc_mode | output | 1 | Global processor-mode flag to the switch core |
| mem_req | output | 1 | Memory request (valid) |
| mem_gnt | input | 1 | Memory grant (ready) from the switch core |
| mem_sel | output | 2 | Memory code: 01 data, 10 low, 11 high |
| mem_stream | output | 2 | Stream of the window |
| mem_chan | output | 5 | Channel within the stream |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_wdata | output | 8 | Write data to the memory |
| mem_rdata | input | 8 | Read data, sampled with the grant |

## Verification
The window is steered through every select code and through split mode. Each memory gets a distinct byte at a distinct stream and channel, so a wrong stream, channel or memory shows up as a mismatch in the model arrays. A write of 0xFF to the control byte, made through an address with bits 4..0 all set, separates the address decode from the readback masking. Writes to the data memory and with the reserved select are counted at the memory port, which tells an ignored write from one that was sent. Grant delays of zero and three cycles, together with a strobe held past done, pin down the completion timing and the single-access rule.

// File: rtl/swhost_pkg.sv
package swhost_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_DATA = 2'b01,
    SEL_LOW  = 2'b10,
    SEL_HIGH = 2'b11
  } msel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DONE,
    ST_HOLD
  } hstate_e;

  typedef struct packed {
    logic  is_ctrl;
    logic  go_mem;
    msel_e sel;
    logic  we;
  } target_t;

  // control byte field positions
  localparam int CTL_SPLIT = 7;
  localparam int CTL_PMODE = 6;
  localparam int CTL_MS_HI = 4;
  localparam int CTL_MS_LO = 3;
  localparam int CTL_ST_HI = 1;
  localparam int CTL_ST_LO = 0;
  localparam logic [7:0] CTL_KEEP  = 8'hDB;
  localparam logic [7:0] HIGH_KEEP = 8'h05;
endpackage

// File: rtl/swhost_decode.sv
module swhost_decode
  import swhost_pkg::*;
(
  input  logic       win,
  input  logic       is_wr,
  input  logic       split,
  input  logic [1:0] msel,
  output target_t    tgt
);
  msel_e sel;

  always_comb begin
    if (split) sel = is_wr ? SEL_LOW : SEL_DATA;
    else       sel = msel_e'(msel);
    tgt.is_ctrl = !win;
    tgt.sel     = sel;
    tgt.we      = is_wr;
    if (is_wr) tgt.go_mem = win && (sel == SEL_LOW || sel == SEL_HIGH);
    else       tgt.go_mem = win && (sel != SEL_NONE);
  end
endmodule

// File: rtl/swhost_ctrl_reg.sv
module swhost_ctrl_reg #(
  parameter int         DATA_W = 8,
  parameter logic [DATA_W-1:0] KEEP = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d & KEEP;
  end
endmodule

// File: rtl/swhost_seq.sv
module swhost_seq
  import swhost_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHAN_W = 5,
  parameter int STRM_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  target_t           tgt,
  input  logic [CHAN_W-1:0] chan_in,
  input  logic [STRM_W-1:0] strm_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [DATA_W-1:0] ctrl_q,
  output logic              ctrl_we,
  output logic              idle,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic [1:0]        mem_sel,
  output logic [STRM_W-1:0] mem_stream,
  output logic [CHAN_W-1:0] mem_chan,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  hstate_e st;
  msel_e   sel_q;
  logic    start;

  assign idle    = (st == ST_IDLE);
  assign start   = idle && (host_rd || host_wr);
  assign ctrl_we = start && tgt.is_ctrl && tgt.we;
  assign done    = (st == ST_DONE);
  assign mem_req = (st == ST_WAIT);
  assign mem_sel = sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      sel_q      <= SEL_NONE;
      mem_stream <= '0;
      mem_chan   <= '0;
      mem_we     <= 1'b0;
      mem_wdata  <= '0;
      rdata      <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          if (tgt.is_ctrl) begin
            if (!tgt.we) rdata <= ctrl_q;
            st <= ST_DONE;
          end else if (tgt.go_mem) begin
            sel_q      <= tgt.sel;
            mem_stream <= strm_in;
            mem_chan   <= chan_in;
            mem_we     <= tgt.we;
            mem_wdata  <= wdata_in;
            st         <= ST_WAIT;
          end else begin
            if (!tgt.we) rdata <= '0;
            st <= ST_DONE;
          end
        end
        ST_WAIT: if (mem_gnt) begin
          if (!mem_we)
            rdata <= (sel_q == SEL_HIGH) ? (mem_rdata & DATA_W'(HIGH_KEEP)) : mem_rdata;
          st <= ST_DONE;
        end
        ST_DONE: st <= ST_HOLD;
        default: if (!host_rd && !host_wr) st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swhost_port.sv
module swhost_port
  import swhost_pkg::*;
#(
  parameter int CHAN_W = 5,
  parameter int STRM_W = 2,
  parameter int DATA_W = 8,
  localparam int ADDR_W = CHAN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd,
  input  logic              host_wr,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_done,
  output logic              proc_mode,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic [1:0]        mem_sel,
  output logic [STRM_W-1:0] mem_stream,
  output logic [CHAN_W-1:0] mem_chan,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [DATA_W-1:0] ctrl_q;
  logic              ctrl_we;
  logic              seq_idle;
  target_t           tgt;

  swhost_decode u_dec (
    .win   (host_addr[ADDR_W-1]),
    .is_wr (host_wr),
    .split (ctrl_q[CTL_SPLIT]),
    .msel  (ctrl_q[CTL_MS_HI:CTL_MS_LO]),
    .tgt   (tgt)
  );

  swhost_ctrl_reg #(.DATA_W(DATA_W), .KEEP(DATA_W'(CTL_KEEP))) u_ctl (
    .clk (clk),
    .rst_n (rst_n),
    .we  (ctrl_we),
    .d   (host_wdata),
    .q   (ctrl_q)
  );

  swhost_seq #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .STRM_W(STRM_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .tgt        (tgt),
    .chan_in    (host_addr[CHAN_W-1:0]),
    .strm_in    (ctrl_q[CTL_ST_LO +: STRM_W]),
    .wdata_in   (host_wdata),
    .ctrl_q     (ctrl_q),
    .ctrl_we    (ctrl_we),
    .idle       (seq_idle),
    .done       (host_done),
    .rdata      (host_rdata),
    .mem_req    (mem_req),
    .mem_gnt    (mem_gnt),
    .mem_sel    (mem_sel),
    .mem_stream (mem_stream),
    .mem_chan   (mem_chan),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata)
  );

  assign proc_mode = ctrl_q[CTL_PMODE];
endmodule

// File: rtl/swhost_chk.sv
module swhost_chk #(
  parameter int CHAN_W = 5,
  parameter int STRM_W = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              idle,
  input logic              host_rd,
  input logic              host_wr,
  input logic [CHAN_W:0]   host_addr,
  input logic [DATA_W-1:0] host_wdata,
  input logic              host_done,
  input logic              proc_mode,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic              mem_we,
  input logic [1:0]        mem_sel,
  input logic [CHAN_W-1:0] mem_chan,
  input logic [STRM_W-1:0] mem_stream
);
  assert_ctrl_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idle && (host_rd || host_wr) && !host_addr[CHAN_W] |=> host_done);

  assert_proc_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    idle && host_wr && !host_addr[CHAN_W] |=> proc_mode == $past(host_wdata[6]));

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_chan) && $stable(mem_stream) && $stable(mem_sel));

  assert_done_after_gnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt |=> host_done);

  assert_no_done_in_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !host_done);

  assert_write_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_sel == 2'b10 || mem_sel == 2'b11);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);
endmodule

bind swhost_port swhost_chk #(.CHAN_W(CHAN_W), .STRM_W(STRM_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .idle       (seq_idle),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_done  (host_done),
  .proc_mode  (proc_mode),
  .mem_req    (mem_req),
  .mem_gnt    (mem_gnt),
  .mem_we     (mem_we),
  .mem_sel    (mem_sel),
  .mem_chan   (mem_chan),
  .mem_stream (mem_stream)
);

// File: tb/sim_swhost_port.sv
module sim_swhost_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_rdata;
  logic       host_done, proc_mode, mem_req, mem_gnt, mem_we;
  logic [1:0] mem_sel, mem_stream;
  logic [4:0] mem_chan;
  logic [7:0] mem_wdata, mem_rdata;

  int n_chk = 0, n_bad = 0, gdly = 0, wcnt = 0, wr_events = 0, cyc = 0;
  logic [7:0] m_data [4][32];
  logic [7:0] m_low  [4][32];
  logic [7:0] m_high [4][32];

  always #2 clk = ~clk;

  swhost_port u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
    .host_done(host_done), .proc_mode(proc_mode), .mem_req(mem_req),
    .mem_gnt(mem_gnt), .mem_sel(mem_sel), .mem_stream(mem_stream),
    .mem_chan(mem_chan), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // switch-core side model: grant after gdly wait cycles
  assign mem_gnt = mem_req && (wcnt >= gdly);
  always_comb begin
    case (mem_sel)
      2'b01:   mem_rdata = m_data[mem_stream][mem_chan];
      2'b10:   mem_rdata = m_low[mem_stream][mem_chan];
      2'b11:   mem_rdata = m_high[mem_stream][mem_chan];
      default: mem_rdata = 8'h00;
    endcase
  end
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!mem_req || mem_gnt) wcnt <= 0; else wcnt <= wcnt + 1;
    if (mem_req && mem_gnt && mem_we) begin
      wr_events <= wr_events + 1;
      case (mem_sel)
        2'b01:   m_data[mem_stream][mem_chan] <= mem_wdata;
        2'b10:   m_low[mem_stream][mem_chan]  <= mem_wdata;
        2'b11:   m_high[mem_stream][mem_chan] <= mem_wdata;
        default: ;
      endcase
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [5:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int cycles);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = wr; host_rd = !wr;
    cycles = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      cycles++;
      if (host_done) break;
    end
    rd = host_rdata;
    host_wr = 1'b0; host_rd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] r; int c;
    check("R1 done", host_done, 0);
    check("R1 mem_req", mem_req, 0);
    check("R1 proc_mode", proc_mode, 0);
    access(0, 6'h00, 8'h00, r, c);
    check("R1 ctrl reset value", r, 0);
  endtask

  task automatic t_ctrl();
    logic [7:0] r; int c;
    access(1, 6'h1F, 8'hFF, r, c);
    check("R4 ctrl write cycles", c, 1);
    check("R11 proc_mode set", proc_mode, 1);
    access(0, 6'h0A, 8'h00, r, c);
    check("R2 R3 ctrl readback", r, 8'hDB);
    check("R4 ctrl read cycles", c, 1);
    access(1, 6'h05, 8'h00, r, c);
    check("R11 proc_mode clear", proc_mode, 0);
  endtask

  task automatic t_low();
    logic [7:0] r; int c;
    access(1, 6'h00, 8'h12, r, c);          // select low, stream 2
    gdly = 3;
    access(1, 6'h25, 8'hA5, r, c);
    check("R10 write cycles with 3 waits", c, 5);
    check("R5 R6 low[2][5]", m_low[2][5], 8'hA5);
    gdly = 0;
    access(0, 6'h25, 8'h00, r, c);
    check("R6 low readback", r, 8'hA5);
    check("R10 read cycles no wait", c, 2);
  endtask

  task automatic t_high();
    logic [7:0] r; int c;
    access(1, 6'h00, 8'h19, r, c);          // select high, stream 1
    access(1, 6'h3F, 8'hFF, r, c);
    check("R6 high[1][31]", m_high[1][31], 8'hFF);
    access(0, 6'h3F, 8'h00, r, c);
    check("R9 high read masked", r, 8'h05);
  endtask

  task automatic t_data();
    logic [7:0] r; int c; int w0;
    m_data[3][7] = 8'h3C;
    access(1, 6'h00, 8'h0B, r, c);          // select data, stream 3
    access(0, 6'h27, 8'h00, r, c);
    check("R6 data read", r, 8'h3C);
    w0 = wr_events;
    access(1, 6'h27, 8'h99, r, c);
    check("R8 data write cycles", c, 1);
    check("R8 data write events", wr_events, w0);
    check("R8 data unchanged", m_data[3][7], 8'h3C);
  endtask

  task automatic t_reserved();
    logic [7:0] r; int c; int w0;
    access(1, 6'h00, 8'h00, r, c);          // select reserved, stream 0
    w0 = wr_events;
    access(1, 6'h21, 8'h5A, r, c);
    check("R8 reserved write cycles", c, 1);
    check("R8 reserved write events", wr_events, w0);
    access(0, 6'h21, 8'h00, r, c);
    check("R8 reserved read value", r, 0);
    check("R8 reserved read cycles", c, 1);
  endtask

  task automatic t_split();
    logic [7:0] r; int c;
    m_data[2][3] = 8'h42; m_high[2][3] = 8'h00;
    access(1, 6'h00, 8'h9A, r, c);          // split, select high, stream 2
    access(1, 6'h23, 8'h77, r, c);
    check("R7 split write to low", m_low[2][3], 8'h77);
    check("R7 split write not high", m_high[2][3], 8'h00);
    access(0, 6'h23, 8'h00, r, c);
    check("R7 split read from data", r, 8'h42);
  endtask

  task automatic t_hold();
    int dones = 0;
    @(negedge clk);
    host_addr = 6'h00; host_rd = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (host_done) dones++;
    end
    check("R12 one done per held strobe", dones, 1);
    host_rd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int s = 0; s < 4; s++)
      for (int ch = 0; ch < 32; ch++) begin
        m_data[s][ch] = 8'h00; m_low[s][ch] = 8'h00; m_high[s][ch] = 8'h00;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_low();
    t_high();
    t_data();
    t_reserved();
    t_split();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cyc >= 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule